// File: doc/BRIEF.md
# Variable-Length CISC Instruction Decoder

This block sits between a byte-wide instruction fetch stream and an execution stage. It takes opcode bytes and any trailing extension bytes one at a time over a valid/ready handshake. It works out how long each instruction is, either one byte or three. When the instruction is complete, it presents a single decoded record: the operation, the destination register, the operand mode, a 16-bit extension word, and an illegal-instruction flag.

The opcode byte holds three fields: a 3-bit class in bits 7..5, a 2-bit register in bits 4..3 and a 3-bit operand in bits 2..0. Class 000 is an escape. Its register field selects one of four groups: zero-operand instructions, jumps, bitwise not, or a reserved group. The decoder therefore resolves the operation across two nested levels, and in the same step decides whether a 16-bit word must follow.

Back-pressure rules for the input are as follows:
- `in_ready` is high in every cycle outside reset, and low while `rst` is high.
- A byte is taken only in a cycle where `in_valid` and `in_ready` are both high.
- Idle cycles may fall between any two bytes, including in the middle of an instruction.
- The output has no ready signal. The consumer must take each record in the cycle its `out_valid` pulse is high.

Top module: `insn_decoder`

## Requirements
- R1: For a class field (bits 7..5) other than 000, the operation code is the class value. The classes are 1 mov-load, 2 add, 3 sub, 4 cmp, 5 and, 6 mov reg/reg or memory source, and 7 mov-store. `out_dst` carries bits 4..3 and `out_mode` carries bits 2..0.
- R2: The operand modes 101 (base plus displacement), 110 (direct address) and 111 (immediate) each make the instruction three bytes long. The two extra bytes form `out_ext`, with the first extra byte as the low byte. Every other instruction is one byte long and has `out_ext` equal to 0.
- R3: A special-class byte 00010mmm decodes as not, with operation code 8, `out_dst` 0 and `out_mode` = mmm. Its length follows the R2 rule for mmm.
- R4: The zero-operand bytes 00000011 to 00000111 decode to operation codes 9 to 13: brk, iret, halt, get and put. They are one byte long, with `out_dst` 0 and `out_mode` 0.
- R5: Bytes 00001iii are always three bytes long, whatever iii is. For iii from 000 to 110, the operation code is 14 + iii, covering je, jne, jb, jbe, ja, jae and jmp. `out_dst` and `out_mode` are 0.
- R6: Reserved codes raise `out_illegal` = 1 and give operation code 0, `out_dst` 0 and `out_mode` 0. The reserved codes are 00000000 to 00000010, 00001111, and 00011mmm. Only the 00001111 form is three bytes long, and its word is still carried in `out_ext`.
- R7: `out_valid` is high for exactly the one cycle after the final byte of an instruction is accepted. It is never high after a non-final byte. Back-to-back instructions give pulses in consecutive cycles.
- R8: `in_ready` is 1 outside reset. Cycles with `in_valid` low between bytes neither advance nor disturb a partly collected instruction.
- R9: A synchronous reset drives `in_ready` and `out_valid` low and discards any partly collected instruction. The next byte accepted after reset is decoded as an opcode.
- R10: The record outputs keep their values in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | One-cycle pulse: a record is presented |
| out_op | output | 5 | Operation code (see R1, R3 to R6) |
| out_dst | output | 2 | Destination register field |
| out_mode | output | 3 | Operand mode field |
| out_ext | output | 16 | Extension word, or 0 for one-byte instructions |
| out_illegal | output | 1 | Reserved code seen |

## Verification
The hardest condition to reach is a partly collected instruction that is then disturbed. This happens in two ways: idle cycles arrive between the opcode and its extension bytes, or reset arrives after only the low extension byte. The bench inserts idle gaps into selected three-byte vectors of its table. It also runs a directed case that resets after two bytes of a direct-address load and then sends a one-byte opcode. That opcode must decode as an opcode and not as a leftover high byte. A further directed case sends one-byte instructions back to back, to show that consecutive pulses each carry their own record.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CLS_W  = 3;
  localparam int REG_W  = 2;
  localparam int MODE_W = 3;
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ILL    = 5'd0,
    OP_MOV_LD = 5'd1,
    OP_ADD    = 5'd2,
    OP_SUB    = 5'd3,
    OP_CMP    = 5'd4,
    OP_AND    = 5'd5,
    OP_MOV_RR = 5'd6,
    OP_MOV_ST = 5'd7,
    OP_NOT    = 5'd8,
    OP_BRK    = 5'd9,
    OP_IRET   = 5'd10,
    OP_HALT   = 5'd11,
    OP_GET    = 5'd12,
    OP_PUT    = 5'd13,
    OP_JE     = 5'd14,
    OP_JNE    = 5'd15,
    OP_JB     = 5'd16,
    OP_JBE    = 5'd17,
    OP_JA     = 5'd18,
    OP_JAE    = 5'd19,
    OP_JMP    = 5'd20
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [REG_W-1:0]  dst;
    logic [MODE_W-1:0] mode;
    logic              illegal;
    logic              needs_ext;
  } dec_t;

  // Operand modes 5, 6 and 7 carry a trailing 16-bit word
  function automatic logic mode_has_word(input logic [MODE_W-1:0] m);
    return m >= 3'd5;
  endfunction
endpackage

// File: rtl/insn_opcode_dec.sv
module insn_opcode_dec
  import insn_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] opc,
  output dec_t              dec
);
  logic [CLS_W-1:0]  cls;
  logic [REG_W-1:0]  grp;
  logic [MODE_W-1:0] sub;

  assign cls = opc[BYTE_W-1 -: CLS_W];
  assign grp = opc[MODE_W +: REG_W];
  assign sub = opc[MODE_W-1:0];

  always_comb begin
    dec         = '0;
    dec.op      = OP_ILL;
    if (cls != '0) begin
      dec.op        = op_e'({2'b00, cls});
      dec.dst       = grp;
      dec.mode      = sub;
      dec.needs_ext = mode_has_word(sub);
    end else begin
      unique case (grp)
        2'b00: begin
          if (sub >= 3'd3) dec.op = op_e'(OP_W'(OP_BRK) + OP_W'(sub - 3'd3));
          else             dec.illegal = 1'b1;
        end
        2'b01: begin
          dec.needs_ext = 1'b1;
          if (sub != 3'd7) dec.op = op_e'(OP_W'(OP_JE) + OP_W'(sub));
          else             dec.illegal = 1'b1;
        end
        2'b10: begin
          dec.op        = OP_NOT;
          dec.mode      = sub;
          dec.needs_ext = mode_has_word(sub);
        end
        default: dec.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/insn_len_fsm.sv
module insn_len_fsm
  import insn_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [BYTE_W-1:0] in_byte,
  input  dec_t              dec,
  output logic              out_valid,
  output op_e               out_op,
  output logic [REG_W-1:0]  out_dst,
  output logic [MODE_W-1:0] out_mode,
  output logic              out_ill,
  output logic [WORD_W-1:0] out_ext
);
  typedef enum logic [1:0] {S_OPC, S_LO, S_HI} st_e;

  st_e               state;
  op_e               held_op;
  logic [REG_W-1:0]  held_dst;
  logic [MODE_W-1:0] held_mode;
  logic              held_ill;
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_OPC;
      out_valid <= 1'b0;
      out_op    <= OP_ILL;
      out_dst   <= '0;
      out_mode  <= '0;
      out_ill   <= 1'b0;
      out_ext   <= '0;
      held_op   <= OP_ILL;
      held_dst  <= '0;
      held_mode <= '0;
      held_ill  <= 1'b0;
      lo_q      <= '0;
    end else begin
      out_valid <= 1'b0;
      if (fire) begin
        unique case (state)
          S_OPC: begin
            if (dec.needs_ext) begin
              held_op   <= dec.op;
              held_dst  <= dec.dst;
              held_mode <= dec.mode;
              held_ill  <= dec.illegal;
              state     <= S_LO;
            end else begin
              out_valid <= 1'b1;
              out_op    <= dec.op;
              out_dst   <= dec.dst;
              out_mode  <= dec.mode;
              out_ill   <= dec.illegal;
              out_ext   <= '0;
            end
          end
          S_LO: begin
            lo_q  <= in_byte;
            state <= S_HI;
          end
          S_HI: begin
            out_valid <= 1'b1;
            out_op    <= held_op;
            out_dst   <= held_dst;
            out_mode  <= held_mode;
            out_ill   <= held_ill;
            out_ext   <= {in_byte, lo_q};
            state     <= S_OPC;
          end
          default: state <= S_OPC;
        endcase
      end
    end
  end

  // R7
  pulse_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(fire));

  // R8
  idle_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(state));

  // R10
  record_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_op) && $stable(out_dst) && $stable(out_mode)
                    && $stable(out_ill) && $stable(out_ext)));
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  output logic [OP_W-1:0]   out_op,
  output logic [REG_W-1:0]  out_dst,
  output logic [MODE_W-1:0] out_mode,
  output logic [WORD_W-1:0] out_ext,
  output logic              out_illegal
);
  dec_t dec_w;
  op_e  op_w;
  logic fire;

  assign in_ready = !rst;
  assign fire     = in_valid && in_ready;

  insn_opcode_dec u_dec (
    .opc (in_byte),
    .dec (dec_w)
  );

  insn_len_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .in_byte   (in_byte),
    .dec       (dec_w),
    .out_valid (out_valid),
    .out_op    (op_w),
    .out_dst   (out_dst),
    .out_mode  (out_mode),
    .out_ill   (out_illegal),
    .out_ext   (out_ext)
  );

  assign out_op = op_w;

  // R6
  illegal_record_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_op == '0 && out_dst == '0 && out_mode == '0));
endmodule

// File: tb/insn_decoder_tb.sv
module insn_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        out_valid;
  logic [4:0]  out_op;
  logic [1:0]  out_dst;
  logic [2:0]  out_mode;
  logic [15:0] out_ext;
  logic        out_illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  insn_decoder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_op(out_op),
    .out_dst(out_dst), .out_mode(out_mode), .out_ext(out_ext),
    .out_illegal(out_illegal)
  );

  // {b0, b1, b2, len, op, dst, mode, illegal}
  localparam int NV = 30;
  localparam logic [36:0] VECS [NV] = '{
    {8'hC1, 8'h00, 8'h00, 2'd1, 5'd6,  2'd0, 3'd1, 1'b0},
    {8'hC6, 8'h00, 8'h10, 2'd3, 5'd6,  2'd0, 3'd6, 1'b0},
    {8'h3F, 8'h34, 8'h12, 2'd3, 5'd1,  2'd3, 3'd7, 1'b0},
    {8'h45, 8'hFE, 8'hFF, 2'd3, 5'd2,  2'd0, 3'd5, 1'b0},
    {8'h6C, 8'h00, 8'h00, 2'd1, 5'd3,  2'd1, 3'd4, 1'b0},
    {8'h92, 8'h00, 8'h00, 2'd1, 5'd4,  2'd2, 3'd2, 1'b0},
    {8'hB3, 8'h00, 8'h00, 2'd1, 5'd5,  2'd2, 3'd3, 1'b0},
    {8'hE6, 8'h00, 8'h20, 2'd3, 5'd7,  2'd0, 3'd6, 1'b0},
    {8'h10, 8'h00, 8'h00, 2'd1, 5'd8,  2'd0, 3'd0, 1'b0},
    {8'h17, 8'hAA, 8'h55, 2'd3, 5'd8,  2'd0, 3'd7, 1'b0},
    {8'h14, 8'h00, 8'h00, 2'd1, 5'd8,  2'd0, 3'd4, 1'b0},
    {8'h03, 8'h00, 8'h00, 2'd1, 5'd9,  2'd0, 3'd0, 1'b0},
    {8'h04, 8'h00, 8'h00, 2'd1, 5'd10, 2'd0, 3'd0, 1'b0},
    {8'h05, 8'h00, 8'h00, 2'd1, 5'd11, 2'd0, 3'd0, 1'b0},
    {8'h06, 8'h00, 8'h00, 2'd1, 5'd12, 2'd0, 3'd0, 1'b0},
    {8'h07, 8'h00, 8'h00, 2'd1, 5'd13, 2'd0, 3'd0, 1'b0},
    {8'h00, 8'h00, 8'h00, 2'd1, 5'd0,  2'd0, 3'd0, 1'b1},
    {8'h01, 8'h00, 8'h00, 2'd1, 5'd0,  2'd0, 3'd0, 1'b1},
    {8'h02, 8'h00, 8'h00, 2'd1, 5'd0,  2'd0, 3'd0, 1'b1},
    {8'h08, 8'h00, 8'h01, 2'd3, 5'd14, 2'd0, 3'd0, 1'b0},
    {8'h09, 8'hCD, 8'hAB, 2'd3, 5'd15, 2'd0, 3'd0, 1'b0},
    {8'h0A, 8'h01, 8'h02, 2'd3, 5'd16, 2'd0, 3'd0, 1'b0},
    {8'h0B, 8'h03, 8'h04, 2'd3, 5'd17, 2'd0, 3'd0, 1'b0},
    {8'h0C, 8'h05, 8'h06, 2'd3, 5'd18, 2'd0, 3'd0, 1'b0},
    {8'h0D, 8'h07, 8'h08, 2'd3, 5'd19, 2'd0, 3'd0, 1'b0},
    {8'h0E, 8'hEF, 8'hBE, 2'd3, 5'd20, 2'd0, 3'd0, 1'b0},
    {8'h0F, 8'h11, 8'h22, 2'd3, 5'd0,  2'd0, 3'd0, 1'b1},
    {8'h18, 8'h00, 8'h00, 2'd1, 5'd0,  2'd0, 3'd0, 1'b1},
    {8'h1F, 8'h00, 8'h00, 2'd1, 5'd0,  2'd0, 3'd0, 1'b1},
    {8'h7D, 8'h80, 8'h00, 2'd3, 5'd3,  2'd3, 3'd5, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
  endtask

  task automatic run_vec(input logic [36:0] v, input int gap);
    logic [7:0]  bs [3];
    logic [1:0]  len;
    logic [15:0] exp_ext;
    string       tag;
    bs[0] = v[36:29]; bs[1] = v[28:21]; bs[2] = v[20:13];
    len   = v[12:11];
    exp_ext = (len == 2'd3) ? {bs[2], bs[1]} : 16'h0000;
    if (bs[0][7:5] != 3'b000)       tag = "R1";
    else if (bs[0][4:3] == 2'b00)   tag = (bs[0][2:0] >= 3'd3) ? "R4" : "R6";
    else if (bs[0][4:3] == 2'b01)   tag = "R5";
    else if (bs[0][4:3] == 2'b10)   tag = "R3";
    else                            tag = "R6";
    for (int i = 0; i < int'(len); i++) begin
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
          chk("R8 idle gap no pulse", 32'(out_valid), 32'd0);
        end
      end
      @(negedge clk);
      if (i > 0) chk("R7 no pulse mid-instruction", 32'(out_valid), 32'd0);
      in_valid = 1'b1;
      in_byte  = bs[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 pulse after last byte", 32'(out_valid), 32'd1);
    chk(tag, 32'(out_op), 32'(v[10:6]));
    chk({tag, " dst"}, 32'(out_dst), 32'(v[5:4]));
    chk({tag, " mode"}, 32'(out_mode), 32'(v[3:1]));
    chk("R6 illegal flag", 32'(out_illegal), 32'(v[0]));
    chk("R2 ext word", 32'(out_ext), 32'(exp_ext));
    @(negedge clk);
    chk("R7 pulse lasts one cycle", 32'(out_valid), 32'd0);
    chk("R10 record held", 32'(out_ext), 32'(exp_ext));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", 32'(out_valid), 32'd0);
    chk("R9 reset in_ready", 32'(in_ready), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 ready after reset", 32'(in_ready), 32'd1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], (i % 5 == 3) ? 2 : 0);

    // R9: reset after opcode and low byte of a direct load, then a one-byte cmp
    send_byte(8'hC6);
    send_byte(8'h34);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 no pulse across reset", 32'(out_valid), 32'd0);
    rst = 1'b0;
    send_byte(8'h92);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 post-reset byte is opcode", 32'(out_valid), 32'd1);
    chk("R9 post-reset op", 32'(out_op), 32'd4);
    chk("R9 post-reset ext", 32'(out_ext), 32'd0);

    // R7: back-to-back one-byte instructions
    send_byte(8'h05);
    send_byte(8'h92);
    chk("R7 first back-to-back pulse", 32'(out_valid), 32'd1);
    chk("R7 first back-to-back op", 32'(out_op), 32'd11);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 second back-to-back pulse", 32'(out_valid), 32'd1);
    chk("R7 second back-to-back op", 32'(out_op), 32'd4);

    // R8: long stall inside a jump, word must stay intact
    send_byte(8'h0E);
    send_byte(8'h78);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 no pulse in long stall", 32'(out_valid), 32'd0);
    send_byte(8'h56);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 jump after stall", 32'(out_op), 32'd20);
    chk("R8 word after stall", 32'(out_ext), 32'h5678);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule